// File: doc/BRIEF.md
# Buffer Pointer Data Port

This block gives a byte-wide host bus access into a packet buffer memory that is split into equal pages. The host first loads a 16-bit pointer as two separate bytes. It then reads or writes buffer bytes through a data window that is four bytes wide. Two control bits in the pointer set how each access is addressed:

- Bit 15 picks the page. When it is set, the page is the current head of the receive queue. When it is clear, the page is the one named by the packet number input.
- Bit 14 picks the addressing mode. When it is set, every access uses the stored offset and then advances it. When it is clear, the byte lane of the window is added to the stored offset and the pointer does not change.

The memory itself sits outside the block. The block drives a flat byte address, write data and a write enable. It returns read data in the same cycle as the access.

Every host cycle falls into one access kind, decoded with a unique case:

- `ACC_IDLE`: no strobe is active.
- `ACC_PTR_LO`: pointer low byte, offset 6.
- `ACC_PTR_HI`: pointer high byte, offset 7.
- `ACC_DATA`: data window, offsets 8 to 11.
- `ACC_OTHER`: any other offset.

The only state is the pointer. Its transitions are:

- reset: the pointer goes to zero.
- byte load: an `ACC_PTR_LO` or `ACC_PTR_HI` write replaces one byte.
- step: an `ACC_DATA` access with bit 14 set advances the low 11 bits.
- hold: every other cycle leaves the pointer unchanged.

Top module: `bufptr_port`

## Requirements
- R1: After reset the pointer is zero, so reads of offsets 6 and 7 return 0x00.
- R2: A host write to offset 6 replaces pointer bits 7:0 only. A host write to offset 7 replaces bits 15:8 only. The other byte keeps its value.
- R3: A read of offset 7 returns pointer bits 15:8 ANDed with 0xF7, so bit 3 of the returned byte (pointer bit 11) always reads as zero. Bit 11 itself is still stored.
- R4: The memory address is page × 2048 + byte offset. The page is `rx_head` when pointer bit 15 is 1, and `pkt_num` when it is 0.
- R5: When pointer bit 14 is 1, a data-window access (offsets 8 to 11, read or write) uses pointer bits 10:0 as the byte offset. After the access, bits 10:0 increment, wrapping from 0x7FF to 0x000, and bits 15:11 are kept.
- R6: When pointer bit 14 is 0, a data-window access uses (pointer bits 10:0 + host_addr[1:0]) modulo 2048 as the byte offset, and the pointer is left unchanged.
- R7: A host write to the data window asserts `mem_we` in the same cycle, with `mem_wdata` equal to `host_wdata`. `mem_we` is low in every other cycle.
- R8: A host read of the data window returns `mem_rdata` on `host_rdata` in the same cycle.
- R9: Accesses to offsets other than 6 to 11 do not change the pointer and do not write memory. Reads of those offsets return 0x00. When both strobes are high, the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| pkt_num | input | 2 | Page named by the packet number register |
| rx_head | input | 2 | Page at the head of the receive queue |
| host_rdata | output | 8 | Host read byte |
| mem_addr | output | 13 | Flat byte address into the buffer memory |
| mem_wdata | output | 8 | Byte written to the memory |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Byte read from the memory at `mem_addr` |

## Verification
The in-line assertions check these rules on every cycle:

- The auto-increment step wraps within 11 bits.
- The top five pointer bits survive a step.
- Fixed-mode accesses and low-byte loads leave the rest of the pointer unchanged.
- Read-back of the high byte always masks bit 11.
- No memory write happens without a host write.

Only the bench scenarios can show the following, by comparing against a behavioural pointer and byte array:

- Page selection works from both sources.
- Lane offsets wrap at the page end.
- Long auto-increment fills read back intact.
- Stray offsets leave memory and pointer untouched.

// File: rtl/bufptr_pkg.sv
package bufptr_pkg;
    localparam int PTR_W        = 16;
    localparam int PTR_RXSEL    = 15;
    localparam int PTR_AUTO     = 14;
    localparam logic [3:0] OFS_PTR_LO = 4'd6;
    localparam logic [3:0] OFS_PTR_HI = 4'd7;
    localparam logic [7:0] HI_READ_MASK = 8'hF7;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_PTR_LO,
        ACC_PTR_HI,
        ACC_DATA,
        ACC_OTHER
    } acc_e;
endpackage

// File: rtl/bufptr_decode.sv
module bufptr_decode
    import bufptr_pkg::*;
(
    input  logic [3:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    output acc_e       acc,
    output logic       acc_wr,
    output logic [1:0] lane
);
    always_comb begin
        acc = ACC_IDLE;
        if (host_wr || host_rd) begin
            unique case (host_addr)
                OFS_PTR_LO:               acc = ACC_PTR_LO;
                OFS_PTR_HI:               acc = ACC_PTR_HI;
                4'd8, 4'd9, 4'd10, 4'd11: acc = ACC_DATA;
                default:                  acc = ACC_OTHER;
            endcase
        end
    end

    // write takes precedence when both strobes are present (R9)
    assign acc_wr = host_wr;
    assign lane   = host_addr[1:0];
endmodule

// File: rtl/bufptr_ptr_reg.sv
module bufptr_ptr_reg
    import bufptr_pkg::*;
#(
    parameter int OFF_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_lo,
    input  logic             load_hi,
    input  logic [7:0]       wdata,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    logic             auto_mode;
    logic [OFF_W-1:0] next_off;

    assign auto_mode = ptr[PTR_AUTO];
    assign next_off  = ptr[OFF_W-1:0] + OFF_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load_lo) begin
            ptr[7:0] <= wdata;
        end else if (load_hi) begin
            ptr[PTR_W-1:8] <= wdata;
        end else if (step && auto_mode) begin
            ptr[OFF_W-1:0] <= next_off;
        end
    end

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && auto_mode && !load_lo && !load_hi) |=>
        (ptr[OFF_W-1:0] == ($past(ptr[OFF_W-1:0]) + OFF_W'(1)))); // R5

    AST_STEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (step && auto_mode) |=>
        (ptr[PTR_W-1:OFF_W] == $past(ptr[PTR_W-1:OFF_W]))); // R5

    AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !auto_mode && !load_lo && !load_hi) |=> $stable(ptr)); // R6

    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        load_lo |=> (ptr[PTR_W-1:8] == $past(ptr[PTR_W-1:8]))); // R2

    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        load_hi |=> (ptr[7:0] == $past(ptr[7:0]))); // R2
endmodule

// File: rtl/bufptr_addr_gen.sv
module bufptr_addr_gen
    import bufptr_pkg::*;
#(
    parameter int PAGES = 4,
    parameter int OFF_W = 11,
    localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int MA_W = PG_W + OFF_W
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic [1:0]       lane,
    input  logic [PG_W-1:0]  pkt_num,
    input  logic [PG_W-1:0]  rx_head,
    output logic [MA_W-1:0]  mem_addr
);
    logic [PG_W-1:0]  page;
    logic [OFF_W-1:0] byte_off;

    always_comb begin
        page     = ptr[PTR_RXSEL] ? rx_head : pkt_num;
        byte_off = ptr[PTR_AUTO] ? ptr[OFF_W-1:0]
                                 : ptr[OFF_W-1:0] + OFF_W'(lane);
    end

    assign mem_addr = {page, byte_off};
endmodule

// File: rtl/bufptr_port.sv
module bufptr_port
    import bufptr_pkg::*;
#(
    parameter int PAGES      = 4,
    parameter int PAGE_BYTES = 2048,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int MA_W      = PG_W + OFF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      host_addr,
    input  logic [7:0]      host_wdata,
    input  logic            host_wr,
    input  logic            host_rd,
    input  logic [PG_W-1:0] pkt_num,
    input  logic [PG_W-1:0] rx_head,
    output logic [7:0]      host_rdata,
    output logic [MA_W-1:0] mem_addr,
    output logic [7:0]      mem_wdata,
    output logic            mem_we,
    input  logic [7:0]      mem_rdata
);
    acc_e             acc;
    logic             acc_wr;
    logic [1:0]       lane;
    logic [PTR_W-1:0] ptr;
    logic             load_lo, load_hi, step;

    bufptr_decode u_decode (
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .acc       (acc),
        .acc_wr    (acc_wr),
        .lane      (lane)
    );

    assign load_lo = (acc == ACC_PTR_LO) && acc_wr;
    assign load_hi = (acc == ACC_PTR_HI) && acc_wr;
    assign step    = (acc == ACC_DATA);

    bufptr_ptr_reg #(.OFF_W(OFF_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_lo (load_lo),
        .load_hi (load_hi),
        .wdata   (host_wdata),
        .step    (step),
        .ptr     (ptr)
    );

    bufptr_addr_gen #(.PAGES(PAGES), .OFF_W(OFF_W)) u_addr (
        .ptr      (ptr),
        .lane     (lane),
        .pkt_num  (pkt_num),
        .rx_head  (rx_head),
        .mem_addr (mem_addr)
    );

    always_comb begin
        mem_we     = 1'b0;
        host_rdata = 8'h00;
        unique case (acc)
            ACC_IDLE, ACC_OTHER: ;
            ACC_PTR_LO: if (!acc_wr) host_rdata = ptr[7:0];
            ACC_PTR_HI: if (!acc_wr) host_rdata = ptr[PTR_W-1:8] & HI_READ_MASK;
            ACC_DATA: begin
                if (acc_wr) mem_we = 1'b1;
                else        host_rdata = mem_rdata;
            end
            default: ;
        endcase
    end

    assign mem_wdata = host_wdata;

    AST_HI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_addr == OFS_PTR_HI) |-> (host_rdata[3] == 1'b0)); // R3

    AST_WE_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (host_wr && host_addr[3:2] == 2'b10)); // R7

    AST_OTHER_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && (host_addr < 4'd6 || host_addr > 4'd11)) |-> (host_rdata == 8'h00)); // R9
endmodule

// File: tb/bufptr_port_tb.sv
module bufptr_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [1:0]  pkt_num = '0;
    logic [1:0]  rx_head = '0;
    logic [7:0]  host_rdata;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;

    logic [7:0]  ram [0:8191];
    logic [7:0]  ref_mem [0:8191];
    logic [15:0] ref_ptr;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bufptr_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .pkt_num(pkt_num), .rx_head(rx_head),
        .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input logic [1:0] ln);
        int pg, off;
        pg  = ref_ptr[15] ? int'(rx_head) : int'(pkt_num);
        off = ref_ptr[14] ? int'(ref_ptr[10:0]) : ((int'(ref_ptr[10:0]) + int'(ln)) % 2048);
        return pg * 2048 + off;
    endfunction

    function automatic bit is_data(input logic [3:0] a);
        return (a >= 4'd8 && a <= 4'd11);
    endfunction

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d, input string req);
        int ea;
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1; host_rd = 1'b0;
        #1;
        ea = exp_addr(a[1:0]);
        if (is_data(a)) begin
            check({req, " R7 we"}, int'(mem_we), 1);
            check({req, " R4 addr"}, int'(mem_addr), ea);
            check({req, " R7 wdata"}, int'(mem_wdata), int'(d));
        end else begin
            check({req, " R9 no we"}, int'(mem_we), 0);
        end
        @(posedge clk);
        if (a == 4'd6) ref_ptr[7:0] = d;
        else if (a == 4'd7) ref_ptr[15:8] = d;
        else if (is_data(a)) begin
            ref_mem[ea] = d;
            if (ref_ptr[14]) ref_ptr[10:0] = ref_ptr[10:0] + 11'd1;
        end
    endtask

    task automatic do_rd(input logic [3:0] a, input string req);
        int ea, exp;
        @(negedge clk);
        host_addr = a; host_wr = 1'b0; host_rd = 1'b1;
        #1;
        ea = exp_addr(a[1:0]);
        if (a == 4'd6) exp = int'(ref_ptr[7:0]);
        else if (a == 4'd7) exp = int'(ref_ptr[15:8] & 8'hF7);
        else if (is_data(a)) begin
            exp = int'(ref_mem[ea]);
            check({req, " R4 addr"}, int'(mem_addr), ea);
        end else exp = 0;
        check({req, " rdata"}, int'(host_rdata), exp);
        check({req, " R7 no we on read"}, int'(mem_we), 0);
        @(posedge clk);
        if (is_data(a) && ref_ptr[14]) ref_ptr[10:0] = ref_ptr[10:0] + 11'd1;
    endtask

    task automatic idle();
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        #1;
        check("R7 idle no we", int'(mem_we), 0);
    endtask

    task automatic set_ptr(input logic [15:0] p);
        do_wr(4'd6, p[7:0], "R2 load lo");
        do_wr(4'd7, p[15:8], "R2 load hi");
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 8192; i++) begin
            ram[i]     = 8'(i * 7 + (i >> 8));
            ref_mem[i] = 8'(i * 7 + (i >> 8));
        end
        ref_ptr = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        do_rd(4'd6, "R1 lo after reset");
        do_rd(4'd7, "R1 hi after reset");

        // R2 byte loads, R3 masked high read
        do_wr(4'd6, 8'h34, "R2");
        do_wr(4'd7, 8'h12, "R2");
        do_rd(4'd6, "R2 lo");
        do_rd(4'd7, "R2 hi");
        do_wr(4'd7, 8'h0F, "R3");
        do_rd(4'd7, "R3 masked hi");
        do_rd(4'd6, "R2 lo kept");

        // R5 auto-increment fill across wrap, page from pkt_num (R4)
        pkt_num = 2'd2; rx_head = 2'd1;
        set_ptr(16'h47FC);
        for (int k = 0; k < 8; k++) do_wr(4'(8 + (k % 4)), 8'(8'hA0 + k), "R5 fill");
        do_rd(4'd6, "R5 lo after wrap");
        do_rd(4'd7, "R5 hi kept");

        // R5 readback with rx_head page select (R4, R8)
        rx_head = 2'd2; pkt_num = 2'd0;
        set_ptr(16'hC7FC);
        for (int k = 0; k < 8; k++) do_rd(4'(8 + (k % 4)), "R8 R5 readback");
        do_rd(4'd7, "R5 hi after reads");

        // bit 11 kept through step, masked on read (R3, R5)
        set_ptr(16'h4FFF);
        do_wr(4'd8, 8'h5A, "R5 bit11");
        do_rd(4'd6, "R5 wrap lo");
        do_rd(4'd7, "R3 bit11 hidden");

        // R6 fixed mode with lanes
        pkt_num = 2'd1;
        set_ptr(16'h0010);
        for (int k = 0; k < 4; k++) do_wr(4'(8 + k), 8'(8'h60 + k), "R6 fixed wr");
        for (int k = 0; k < 4; k++) do_rd(4'(8 + k), "R6 fixed rd");
        do_rd(4'd6, "R6 ptr unchanged");
        set_ptr(16'h07FE);
        do_wr(4'd11, 8'hC3, "R6 lane wrap");
        do_rd(4'd11, "R6 lane wrap rd");
        do_rd(4'd9, "R6 lane 1");

        // R9 other offsets
        do_wr(4'd3, 8'hFF, "R9 stray wr");
        do_wr(4'd12, 8'h00, "R9 stray wr");
        do_rd(4'd0, "R9 stray rd");
        do_rd(4'd6, "R9 ptr lo kept");
        do_rd(4'd7, "R9 ptr hi kept");
        do_rd(4'd8, "R9 mem kept");

        // R9 write wins when both strobes high
        @(negedge clk);
        host_addr = 4'd6; host_wdata = 8'h77; host_wr = 1'b1; host_rd = 1'b1;
        @(posedge clk);
        ref_ptr[7:0] = 8'h77;
        do_rd(4'd6, "R9 both strobes");

        idle();
        summary();
    end
endmodule